// File: doc/BRIEF.md
# DRAM Nominal Termination Timing Controller

This block drives the on-die termination of a DDR3-style memory device in synchronous mode. On every rising clock edge it registers the termination request pin. It decodes the three nominal-termination select bits of mode register 1 into a resistor divider code. It then switches the termination-enable output on and off after a latency. That latency is the write CAS latency plus the additive latency, minus two cycles.

The block also watches how the pin is used and raises error pulses in these cases:
- the pin drops before its minimum high time has passed, after assertion or after a write;
- termination is requested while a read or self refresh is active;
- a divider that is not allowed during writes is active while a write is in progress;
- the select bits hold a reserved encoding.

The enable output stays low until the device reports that initialization and calibration are complete.

Top module: `odt_nom_ctrl`

## Requirements
- R1: `rtt_div` gives the divisor n of the 240-ohm reference as a plain binary number, decoded from `rtt_sel` = {MR1 bit 9, bit 6, bit 2}: 000→0 (nominal termination disabled), 001→4, 010→2, 011→6, 100→12, 101→8, 110→0, 111→0.
- R2: When `rtt_sel` is 110 or 111, `err_cfg` is high whatever the pin level, and `term_en` is low.
- R3: Let L = `cwl` + `al` − 2, clamped to the range 0..MAX_LAT. After the clock edge k, `term_en` equals `ready` AND (`rtt_div` ≠ 0) AND the value of `odt_pin` registered at edge k−L. Pin values from before reset count as low. Turn-on and turn-off use the same latency.
- R4: A low pin registered within 4 edges of any of these events raises `err_min_high`: a low-to-high transition of the registered pin, or a `wr_bc4` registered while the pin is high. The events' own edge counts as the first of the 4.
- R5: A low pin registered within 6 edges of a `wr_bl8` registered while the pin is high raises `err_min_high`. When events overlap, the later end of their windows applies.
- R6: `err_min_high` is a one-cycle pulse. It is high during the cycle after the edge that registered the offending low, and that low clears all pending minimum-high windows.
- R7: `err_rd_sref` is high during the cycle after an edge that registers `odt_pin` high while `rd_active` or `sref_active` is high.
- R8: `err_wr_value` is high during the cycle after an edge at which `wr_busy` is high, `term_en` is high and `rtt_div` is not 2, 4 or 6.
- R9: While `ready` is low, `term_en` is low.
- R10: While `rst_n` is low and in the cycle that follows it, all registered state is cleared: `term_en`, `err_min_high`, `err_rd_sref` and `err_wr_value` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| odt_pin | input | 1 | Termination request pin, registered on each rising edge |
| rtt_sel | input | 3 | Nominal termination select {MR1[9], MR1[6], MR1[2]} |
| cwl | input | CWL_W | Write CAS latency in cycles |
| al | input | AL_W | Additive latency in cycles |
| ready | input | 1 | Initialization and calibration complete |
| wr_bc4 | input | 1 | Chopped (4-beat) write registered this edge |
| wr_bl8 | input | 1 | Full 8-beat write registered this edge |
| wr_busy | input | 1 | A write data transfer is in progress |
| rd_active | input | 1 | A read is in progress |
| sref_active | input | 1 | Device is in self refresh |
| term_en | output | 1 | Nominal termination enable |
| rtt_div | output | 4 | Divisor n of the reference resistor, 0 when off |
| err_cfg | output | 1 | Reserved select encoding programmed |
| err_min_high | output | 1 | Minimum pin-high time violated |
| err_rd_sref | output | 1 | Termination requested during a read or self refresh |
| err_wr_value | output | 1 | Divider not allowed during a write is active |

## Verification
Assertions check the following on every cycle:
- enable gating by `ready` and by the reserved encodings;
- the read and self-refresh error after each offending edge;
- that a write-value error always traces back to a busy write;
- the short pin patterns behind the minimum-high errors: a one-cycle high after a rise, and a drop right after a full-burst write.

Only the bench scenarios can show the exact latency alignment for each `cwl`/`al` pair. The same holds for overlapping windows from mixed write types, the exact edge at which a window ends, and the full decode table. The bench compares every output against a history-based model on each step.

// File: rtl/odt_pkg.sv
package odt_pkg;

  typedef logic [3:0] rtt_div_t;

  // Divider n of the reference resistor for a select code, 0 when off or reserved.
  function automatic rtt_div_t rtt_divider(input logic [2:0] sel);
    case (sel)
      3'b001:  return 4'd4;
      3'b010:  return 4'd2;
      3'b011:  return 4'd6;
      3'b100:  return 4'd12;
      3'b101:  return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic rtt_reserved(input logic [2:0] sel);
    return sel[2] & sel[1];
  endfunction

  // Dividers allowed while a write uses nominal termination.
  function automatic logic write_safe(input rtt_div_t n);
    return (n == 4'd2) || (n == 4'd4) || (n == 4'd6);
  endfunction

  // Synchronous latency: write CAS latency plus additive latency minus two, clamped.
  function automatic int odt_latency(input int cwl_c, input int al_c, input int max_l);
    int v;
    v = cwl_c + al_c - 2;
    if (v < 0) v = 0;
    if (v > max_l) v = max_l;
    return v;
  endfunction

endpackage

// File: rtl/odt_lat_pipe.sv
module odt_lat_pipe #(
  parameter int MAX_LAT = 24,
  localparam int LAT_W = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [LAT_W-1:0] lat,
  output logic             dout
);

  // stage[k] holds the pin value registered k edges ago
  logic [MAX_LAT:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= 1'b0;
    else        stage[0] <= din;
  end

  for (genvar g = 1; g <= MAX_LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[g] <= 1'b0;
      else        stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[lat];

endmodule

// File: rtl/odt_minhigh_chk.sv
module odt_minhigh_chk #(
  parameter int HOLD_PIN = 4,
  parameter int HOLD_BL8 = 6,
  localparam int CNT_W = $clog2(HOLD_BL8 + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic wr_bc4,
  input  logic wr_bl8,
  output logic viol
);

  localparam logic [CNT_W-1:0] NEED_PIN = CNT_W'(HOLD_PIN - 1);
  localparam logic [CNT_W-1:0] NEED_BL8 = CNT_W'(HOLD_BL8 - 1);

  logic             pin_d;
  logic [CNT_W-1:0] cnt;   // further high samples still required
  logic [CNT_W-1:0] need;
  logic             rise;

  always_comb begin
    rise = pin && !pin_d;
    need = (cnt != '0) ? cnt - 1'b1 : '0;
    if ((rise || (wr_bc4 && pin)) && need < NEED_PIN) need = NEED_PIN;
    if (wr_bl8 && pin && need < NEED_BL8) need = NEED_BL8;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_d <= 1'b0;
      cnt   <= '0;
      viol  <= 1'b0;
    end else begin
      pin_d <= pin;
      if (!pin) begin
        viol <= (cnt != '0);
        cnt  <= '0;
      end else begin
        viol <= 1'b0;
        cnt  <= need;
      end
    end
  end

  AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin ##1 pin ##1 !pin) |=> viol);  // R4
  AST_BL8_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_bl8 && pin) ##1 !pin) |=> viol);  // R5
  AST_VIOL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !pin_d);  // R6

endmodule

// File: rtl/odt_nom_ctrl.sv
module odt_nom_ctrl
  import odt_pkg::*;
#(
  parameter int CWL_W   = 4,
  parameter int AL_W    = 4,
  parameter int MAX_LAT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             odt_pin,
  input  logic [2:0]       rtt_sel,
  input  logic [CWL_W-1:0] cwl,
  input  logic [AL_W-1:0]  al,
  input  logic             ready,
  input  logic             wr_bc4,
  input  logic             wr_bl8,
  input  logic             wr_busy,
  input  logic             rd_active,
  input  logic             sref_active,
  output logic             term_en,
  output logic [3:0]       rtt_div,
  output logic             err_cfg,
  output logic             err_min_high,
  output logic             err_rd_sref,
  output logic             err_wr_value
);

  localparam int LAT_W = $clog2(MAX_LAT + 1);

  logic [LAT_W-1:0] lat;
  rtt_div_t         n_val;
  logic             rsv;
  logic             delayed_pin;
  logic             rtt_on;

  always_comb begin
    n_val  = rtt_divider(rtt_sel);
    rsv    = rtt_reserved(rtt_sel);
    rtt_on = (n_val != '0);
    lat    = LAT_W'(odt_latency(int'(cwl), int'(al), MAX_LAT));
  end

  odt_lat_pipe #(.MAX_LAT(MAX_LAT)) i_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (odt_pin),
    .lat  (lat),
    .dout (delayed_pin)
  );

  odt_minhigh_chk #(.HOLD_PIN(4), .HOLD_BL8(6)) i_minhigh (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (odt_pin),
    .wr_bc4(wr_bc4),
    .wr_bl8(wr_bl8),
    .viol  (err_min_high)
  );

  assign rtt_div = n_val;
  assign err_cfg = rsv;
  assign term_en = ready && rtt_on && delayed_pin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_rd_sref  <= 1'b0;
      err_wr_value <= 1'b0;
    end else begin
      err_rd_sref  <= odt_pin && (rd_active || sref_active);
      err_wr_value <= wr_busy && term_en && !write_safe(n_val);
    end
  end

  AST_IDLE_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !term_en);  // R9
  AST_RESERVED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rtt_sel[2] && rtt_sel[1]) |-> !term_en);  // R2
  AST_RD_SREF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_pin && (rd_active || sref_active)) |=> err_rd_sref);  // R7
  AST_WR_VALUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr_value |-> $past(wr_busy));  // R8

endmodule

// File: tb/test_odt_nom_ctrl.sv
module test_odt_nom_ctrl;

  localparam int MAX_LAT = 24;
  localparam int NSTEP   = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       odt_pin = 1'b0;
  logic [2:0] rtt_sel = 3'b000;
  logic [3:0] cwl = 4'd5;
  logic [3:0] al = 4'd0;
  logic       ready = 1'b0;
  logic       wr_bc4 = 1'b0, wr_bl8 = 1'b0, wr_busy = 1'b0;
  logic       rd_active = 1'b0, sref_active = 1'b0;
  logic       term_en, err_cfg, err_min_high, err_rd_sref, err_wr_value;
  logic [3:0] rtt_div;

  int checks = 0, fails = 0;
  bit done = 0;
  bit ph [0:NSTEP-1];
  int k = 0;
  int req_end = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  odt_nom_ctrl #(.CWL_W(4), .AL_W(4), .MAX_LAT(MAX_LAT)) i_odt_nom_ctrl (
    .clk(clk), .rst_n(rst_n), .odt_pin(odt_pin), .rtt_sel(rtt_sel), .cwl(cwl), .al(al),
    .ready(ready), .wr_bc4(wr_bc4), .wr_bl8(wr_bl8), .wr_busy(wr_busy),
    .rd_active(rd_active), .sref_active(sref_active), .term_en(term_en), .rtt_div(rtt_div),
    .err_cfg(err_cfg), .err_min_high(err_min_high), .err_rd_sref(err_rd_sref),
    .err_wr_value(err_wr_value));

  function automatic int exp_div(input logic [2:0] s);
    int tbl [8] = '{0, 4, 2, 6, 12, 8, 0, 0};
    return tbl[s];
  endfunction

  function automatic int exp_lat(input int c, input int a);
    int v = c + a - 2;
    return (v < 0) ? 0 : ((v > MAX_LAT) ? MAX_LAT : v);
  endfunction

  function automatic bit pin_at(input int idx);
    return (idx < 0) ? 1'b0 : ph[idx];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (step %0d)", req, what, act, exp, k);
    end
  endtask

  // One clock: inputs are applied now (after a falling edge), outputs checked at the next falling edge.
  task automatic step(input bit p, input bit bc4, input bit bl8, input bit busy, input bit rd, input bit sr);
    int  lv, n;
    bit  term_prev, e_min, e_rs, e_wv, term_exp;
    odt_pin = p; wr_bc4 = bc4; wr_bl8 = bl8; wr_busy = busy; rd_active = rd; sref_active = sr;
    lv = exp_lat(int'(cwl), int'(al));
    n  = exp_div(rtt_sel);
    term_prev = ready && (n != 0) && pin_at(k - 1 - lv);
    ph[k] = p;
    // minimum-high windows, ends counted as the first step no longer covered
    e_min = 1'b0;
    if (!p) begin
      e_min = (k < req_end);
      req_end = 0;
    end else begin
      if (!pin_at(k - 1) || bc4) req_end = (req_end > k + 4) ? req_end : k + 4;
      if (bl8)                   req_end = (req_end > k + 6) ? req_end : k + 6;
    end
    e_rs = p && (rd || sr);
    e_wv = busy && term_prev && !(n == 2 || n == 4 || n == 6);
    term_exp = ready && (n != 0) && pin_at(k - lv);
    @(posedge clk);
    @(negedge clk);
    chk("R3", "term_en", int'(term_en), int'(term_exp));
    chk("R1", "rtt_div", int'(rtt_div), n);
    chk("R2", "err_cfg", int'(err_cfg), int'(rtt_sel[2] & rtt_sel[1]));
    chk("R6", "err_min_high", int'(err_min_high), int'(e_min));
    chk("R7", "err_rd_sref", int'(err_rd_sref), int'(e_rs));
    chk("R8", "err_wr_value", int'(err_wr_value), int'(e_wv));
    k++;
  endtask

  task automatic set_cfg(input logic [2:0] s, input int c, input int a, input bit r);
    rtt_sel = s; cwl = 4'(c); al = 4'(a); ready = r;
  endtask

  initial begin
    void'($urandom(32'h0D7C_5A11));
    ready = 1'b1; rtt_sel = 3'b010; odt_pin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "term_en in reset", int'(term_en), 0);
    chk("R10", "err_min_high in reset", int'(err_min_high), 0);
    chk("R10", "err_rd_sref in reset", int'(err_rd_sref), 0);
    chk("R10", "err_wr_value in reset", int'(err_wr_value), 0);
    odt_pin = 1'b0;
    rst_n = 1'b1;

    // R3: turn-on / turn-off latency, cwl=6 al=1 -> 5
    set_cfg(3'b001, 6, 1, 1'b1);
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0);
    // R4: pin high for 3 steps then low -> violation; exactly 4 -> none
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R5: full-burst write extends window to 6; drop after 5 fails, after 6 passes
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
    step(1, 0, 1, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R4: chopped write on a long high restarts a 4-step window
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R7: read and self refresh
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, i == 1, i == 3);
    step(0, 0, 0, 0, 1, 1);
    // R9: not ready keeps termination off
    set_cfg(3'b011, 5, 0, 1'b0);
    for (int i = 0; i < 10; i++) step(1, 0, 0, 1, 0, 0);
    // R2: reserved encodings, R8: /12 during a write
    set_cfg(3'b110, 5, 0, 1'b1);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 0, 0);
    set_cfg(3'b111, 5, 0, 1'b1);
    step(0, 0, 0, 0, 0, 0);
    set_cfg(3'b100, 5, 0, 1'b1);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // constrained random segments
    for (int seg = 0; seg < 16; seg++) begin
      bit p;
      set_cfg(3'($urandom_range(0, 7)), $urandom_range(5, 10), $urandom_range(0, 9),
              ($urandom_range(0, 5) != 0));
      p = 1'b0;
      for (int i = 0; i < 200; i++) begin
        bit bc4, bl8;
        if ($urandom_range(0, 5) == 0) p = ~p;
        bc4 = p && ($urandom_range(0, 11) == 0);
        bl8 = p && !bc4 && ($urandom_range(0, 11) == 0);
        step(p, bc4, bl8, ($urandom_range(0, 2) == 0), ($urandom_range(0, 15) == 0),
             ($urandom_range(0, 23) == 0));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule